// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request (bus number, device/function number and register offset) into the two values that software or a sequencer writes to reach PCI configuration space through a local-to-PCI translation window. The first is the byte offset inside the configuration aperture. The second is the window's map value. The map value carries the configuration cycle type code, the address-low mode bit, and any device-select bits that do not fit inside the aperture.

Requests on bus 0 target the local segment and produce a type 0 pattern. In that pattern the device select is one-hot. The select bit sits in the offset for low slot numbers and moves into the map value for slots above 12. Requests on any other bus produce a type 1 pattern, which carries the bus and device/function fields directly. Inputs are one bit wider than a byte so that out-of-range values can be presented; such requests are flagged as illegal. A request is taken on a one-cycle strobe. The results appear one cycle later, together with a one-cycle done pulse, and are held until the next request.

Top module: `cfgaddr_gen`

## Requirements
- R1: After reset, `cfgOffset`, `mapValue`, `done` and `illegal` are all zero.
- R2: `done` is high exactly in the cycle after a cycle with `reqValid` high. The outputs take their new values in that same cycle and keep them while no new request arrives.
- R3: `mapValue[3:1]` is always 3'b101 for a legal request. `mapValue[0]` is 0 when `busNum` is 0 (type 0) and 1 otherwise (type 1).
- R4: Type 0 places the function number (devFn[2:0]) at `cfgOffset[10:8]` and the register offset at `cfgOffset[7:0]`.
- R5: Type 0 with slot (devFn[7:3]) of 12 or less sets `cfgOffset` bit slot+11. In this case `mapValue` bits above 3 are zero.
- R6: Type 0 with slot above 12 sets `mapValue` bit slot-5 and leaves `cfgOffset[23:11]` all zero.
- R7: Type 1 gives `cfgOffset` = {busNum[7:0], devFn[7:0], regOff[7:0]} and `mapValue` = 32'hB.
- R8: If any of `busNum`, `devFn` or `regOff` exceeds 255, `illegal` is 1 and both `cfgOffset` and `mapValue` are zero. For a legal request, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe |
| busNum | input | 9 | Bus number |
| devFn | input | 9 | Device (bits 7:3) and function (bits 2:0) |
| regOff | input | 9 | Configuration register byte offset |
| cfgOffset | output | 24 | Offset into the configuration aperture |
| mapValue | output | 32 | Window map value: type code, low-address mode, high select bits |
| done | output | 1 | Result-valid pulse |
| illegal | output | 1 | Last request had an out-of-range input |

## Verification
Directed requests on bus 0 sweep every slot from 0 to 31. This separates the offset-resident select (slots up to 12) from the map-resident select (slots 13 and above), and checks the boundary between slots 12 and 13. Bus 1 and bus 255 requests with varied function and register bits show the type 1 field packing and the set address-low bit. Values of 256 and above on each input in turn show that each input alone trips the illegal path. Seeded random requests, mostly legal, mix all of these paths. Gaps between requests show that the results are held.

// File: rtl/cfgaddr_pkg.sv
package cfgaddr_pkg;
  typedef struct packed {
    logic load;
    logic bad;
  } cfgStrobe_t;

  localparam logic [2:0] CFG_TYPE_CODE = 3'b101;
endpackage

// File: rtl/cfgaddr_ctrl.sv
module cfgaddr_ctrl
  import cfgaddr_pkg::*;
#(
  parameter int IN_W = 9,
  parameter int LIMIT = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic [IN_W-1:0] busNum,
  input  logic [IN_W-1:0] devFn,
  input  logic [IN_W-1:0] regOff,
  output cfgStrobe_t      strobe,
  output logic            done
);
  localparam logic [IN_W-1:0] MAX_VAL = IN_W'(LIMIT);

  logic outOfRange;
  assign outOfRange = (busNum > MAX_VAL) || (devFn > MAX_VAL) || (regOff > MAX_VAL);

  always_comb begin
    strobe.load = reqValid;
    strobe.bad  = reqValid && outOfRange;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= reqValid;
  end

  // R2: a request is answered with a pulse in the next cycle
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> done);
  assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !done);
endmodule

// File: rtl/cfgaddr_datapath.sv
module cfgaddr_datapath
  import cfgaddr_pkg::*;
#(
  parameter int IN_W = 9,
  parameter int OFF_W = 24,
  parameter int MAP_W = 32,
  parameter int SLOT_SPLIT = 12,
  parameter int SLOT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfgStrobe_t       strobe,
  input  logic [IN_W-1:0]  busNum,
  input  logic [IN_W-1:0]  devFn,
  input  logic [IN_W-1:0]  regOff,
  output logic [OFF_W-1:0] cfgOffset,
  output logic [MAP_W-1:0] mapValue,
  output logic             illegal
);
  localparam int NUM_SLOTS   = 1 << SLOT_W;
  localparam int SEL_LSB     = 11;
  localparam int WINDOW_BITS = 16;
  localparam int MAP_SHIFT   = SEL_LSB - WINDOW_BITS;

  logic [SLOT_W-1:0] slot;
  logic [2:0]        func;
  logic              remoteBus;
  logic [OFF_W-1:0]  offSel;
  logic [MAP_W-1:0]  mapSel;
  logic [OFF_W-1:0]  offNext;
  logic [MAP_W-1:0]  mapNext;

  assign slot      = devFn[7:3];
  assign func      = devFn[2:0];
  assign remoteBus = (busNum != '0);

  // one decoder per slot; each slot drives either an offset bit or a map bit
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s <= SLOT_SPLIT) begin : g_low
      assign offSel[s+SEL_LSB] = (slot == SLOT_W'(s));
    end else begin : g_high
      assign mapSel[s+MAP_SHIFT] = (slot == SLOT_W'(s));
    end
  end
  assign offSel[SEL_LSB-1:0] = '0;
  if (SLOT_SPLIT + SEL_LSB + 1 < OFF_W) begin : g_offpad
    assign offSel[OFF_W-1:SLOT_SPLIT+SEL_LSB+1] = '0;
  end
  assign mapSel[SLOT_SPLIT+1+MAP_SHIFT-1:0] = '0;
  if (NUM_SLOTS + MAP_SHIFT < MAP_W) begin : g_mappad
    assign mapSel[MAP_W-1:NUM_SLOTS+MAP_SHIFT] = '0;
  end

  always_comb begin
    if (remoteBus) begin
      offNext = OFF_W'({busNum[7:0], devFn[7:0], regOff[7:0]});
      mapNext = MAP_W'({CFG_TYPE_CODE, 1'b1});
    end else begin
      offNext = offSel | OFF_W'({func, regOff[7:0]});
      mapNext = mapSel | MAP_W'({CFG_TYPE_CODE, 1'b0});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgOffset <= '0;
      mapValue  <= '0;
      illegal   <= 1'b0;
    end else if (strobe.load) begin
      illegal   <= strobe.bad;
      cfgOffset <= strobe.bad ? '0 : offNext;
      mapValue  <= strobe.bad ? '0 : mapNext;
    end
  end

  // R8: an illegal result never carries an address
  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cfgOffset == '0 && mapValue == '0));
  // R3: a legal result always carries the configuration type code
  assert_type_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal && mapValue != '0) |-> (mapValue[3:1] == CFG_TYPE_CODE));
  // R5/R6: exactly one device select across offset and map in type 0
  assert_onehot_select_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal && mapValue != '0 && !mapValue[0]) |->
      ($countones(cfgOffset[OFF_W-1:SEL_LSB]) + $countones(mapValue[MAP_W-1:4]) == 1));
  // R2: results hold between requests
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(cfgOffset) && $stable(mapValue) && $stable(illegal)));
endmodule

// File: rtl/cfgaddr_gen.sv
module cfgaddr_gen
  import cfgaddr_pkg::*;
#(
  parameter int IN_W = 9,
  parameter int LIMIT = 255,
  parameter int OFF_W = 24,
  parameter int MAP_W = 32,
  parameter int SLOT_SPLIT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [IN_W-1:0]  busNum,
  input  logic [IN_W-1:0]  devFn,
  input  logic [IN_W-1:0]  regOff,
  output logic [OFF_W-1:0] cfgOffset,
  output logic [MAP_W-1:0] mapValue,
  output logic             done,
  output logic             illegal
);
  cfgStrobe_t strobe;

  cfgaddr_ctrl #(.IN_W(IN_W), .LIMIT(LIMIT)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .busNum(busNum), .devFn(devFn), .regOff(regOff),
    .strobe(strobe), .done(done)
  );

  cfgaddr_datapath #(.IN_W(IN_W), .OFF_W(OFF_W), .MAP_W(MAP_W),
                     .SLOT_SPLIT(SLOT_SPLIT)) i_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .busNum(busNum), .devFn(devFn), .regOff(regOff),
    .cfgOffset(cfgOffset), .mapValue(mapValue), .illegal(illegal)
  );
endmodule

// File: tb/test_cfgaddr_gen.sv
module test_cfgaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [8:0]  busNum = '0, devFn = '0, regOff = '0;
  logic [23:0] cfgOffset;
  logic [31:0] mapValue;
  logic        done, illegal;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  cfgaddr_gen i_cfgaddr_gen (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .busNum(busNum), .devFn(devFn), .regOff(regOff),
    .cfgOffset(cfgOffset), .mapValue(mapValue), .done(done), .illegal(illegal)
  );

  function automatic void expect_of(input logic [8:0] b, input logic [8:0] d,
      input logic [8:0] r, output logic [23:0] eOff, output logic [31:0] eMap,
      output logic eBad);
    int s;
    eBad = (b > 255) || (d > 255) || (r > 255);
    s = int'(d[7:3]);
    if (eBad) begin
      eOff = '0; eMap = '0;
    end else if (b == 0) begin
      eOff = {13'd0, d[2:0], r[7:0]};
      eMap = 32'hA;
      if (s <= 12) eOff = eOff | (24'd1 << (s + 11));
      else         eMap = eMap | (32'd1 << (s - 5));
    end else begin
      eOff = {b[7:0], d[7:0], r[7:0]};
      eMap = 32'hB;
    end
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [8:0] b, input logic [8:0] d, input logic [8:0] r,
                       input string req, input bit checkHold);
    logic [23:0] eOff; logic [31:0] eMap; logic eBad;
    expect_of(b, d, r, eOff, eMap, eBad);
    @(negedge clk);
    busNum = b; devFn = d; regOff = r; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    busNum = 9'h1FF; devFn = 9'h1FF; regOff = 9'h1FF;
    check({req, " done"}, 64'(done), 64'(1));
    check({req, " offset"}, 64'(cfgOffset), 64'(eOff));
    check({req, " map"}, 64'(mapValue), 64'(eMap));
    check({req, " illegal R8"}, 64'(illegal), 64'(eBad));
    if (checkHold) begin
      @(negedge clk);
      check("R2 done drops", 64'(done), 64'(0));
      check("R2 offset held", 64'(cfgOffset), 64'(eOff));
      check("R2 map held", 64'(mapValue), 64'(eMap));
    end
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 offset", 64'(cfgOffset), 64'(0));
    check("R1 map", 64'(mapValue), 64'(0));
    check("R1 done", 64'(done), 64'(0));
    check("R1 illegal", 64'(illegal), 64'(0));
    rst_n = 1'b1;

    // R4 R5 R6: every slot on the local segment, function and register varied
    for (int s = 0; s < 32; s++)
      issue(9'd0, {1'b0, 5'(s), 3'(s % 8)}, {1'b0, 8'(s * 4 + 1)},
            (s <= 12) ? "R5 type0 low slot" : "R6 type0 high slot", s % 4 == 0);
    issue(9'd0, {1'b0, 5'd12, 3'd7}, 9'd252, "R5 slot 12 edge", 1'b1);
    issue(9'd0, {1'b0, 5'd13, 3'd0}, 9'd0, "R6 slot 13 edge", 1'b1);
    issue(9'd0, 9'd0, 9'd3, "R4 regoff low bits", 1'b0);
    // R3 R7: remote segments
    issue(9'd1, 9'd0, 9'd0, "R7 bus1 zero", 1'b1);
    issue(9'd255, 9'd255, 9'd255, "R7 all ones", 1'b0);
    issue(9'd37, 9'h5A, 9'h8C, "R3 type1 code", 1'b0);
    // R8: each input alone out of range
    issue(9'd256, 9'd8, 9'd4, "R8 bus illegal", 1'b1);
    issue(9'd0, 9'd256, 9'd4, "R8 devfn illegal", 1'b0);
    issue(9'd2, 9'd8, 9'd300, "R8 regoff illegal", 1'b0);
    issue(9'd0, 9'd8, 9'd255, "R8 recovery legal", 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic [8:0] b, d, r;
      b = ($urandom % 3 == 0) ? 9'd0 : {1'b0, 8'($urandom)};
      d = {1'b0, 8'($urandom)};
      r = {1'b0, 8'($urandom)};
      if ($urandom % 10 == 0) b[8] = 1'b1;
      if ($urandom % 10 == 0) d[8] = 1'b1;
      if ($urandom % 10 == 0) r[8] = 1'b1;
      issue(b, d, r, "R3 R7 R8 random", n % 7 == 0);
      if ($urandom % 4 == 0) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule